// File: doc/BRIEF.md
# Dual-Modulus Alternating Clock Divider

This block derives a slower clock from a fast source clock with a ratio finer than a plain integer divider gives. Two integer dividers, A and B, take turns. Divider A produces a programmed number of output periods, then divider B produces its own programmed number, and the pattern repeats. The long-run output rate is therefore `f_in * (RA + RB) / (DA*RA + DB*RB)`, where D is a divide value and R is a repeat count. A typical use is a precise 32.768 kHz timebase for always-on or low-power logic, taken from a source that is not a power-of-two multiple of it. A single-divider mode bypasses the alternation and divides by DA alone.

All four configuration fields hold the real value minus one. The block copies the configuration into an active set at reset. After reset it takes a new configuration only at the end of a complete A-then-B sequence, or at the end of any period in single mode. A truncated or merged period therefore never reaches the outputs. The block has two outputs. The first is a one-cycle enable pulse per output period. The second is a registered clock-level signal that is high for the first half of each period.

Top module: `dual_ratio_clkdiv`

## Requirements
- R1: While `rst` is high, `tick_o` and `clk_o` are 0. The configuration present at reset is the first one used, and the first period after reset uses divider A.
- R2: With `dual_en` = 0, `tick_o` pulses once every `div_a`+1 source cycles.
- R3: Each field is minus-one encoded. A `div_*` value of 0 divides by 1, so `tick_o` is high on every cycle. A `rep_*` value of 0 gives exactly one period.
- R4: With `dual_en` = 1, the output periods follow this order: `rep_a`+1 periods of `div_a`+1 cycles, then `rep_b`+1 periods of `div_b`+1 cycles, repeated without end.
- R5: In dual mode each complete sequence lasts exactly (`div_a`+1)(`rep_a`+1) + (`div_b`+1)(`rep_b`+1) source cycles.
- R6: A configuration change takes effect only after the current sequence completes (dual mode) or after the current period completes (single mode). A change made in the middle of a sequence does not alter any period of that sequence.
- R7: In single mode, `rep_a`, `div_b` and `rep_b` have no effect on the output, and the repeat counter is held at its reset value.
- R8: `tick_o` is high for exactly one source cycle per output period, except that a divide of 1 keeps it high continuously.
- R9: `clk_o` is high for max(1, floor(D/2)) source cycles of each D-cycle period. The high time starts on the cycle after the previous `tick_o` pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Source clock |
| rst | input | 1 | Synchronous active-high reset |
| dual_en | input | 1 | 1 = alternate dividers A and B, 0 = divider A only |
| div_a | input | DIV_W | Divider A value minus one |
| rep_a | input | REP_W | Periods from divider A per sequence, minus one |
| div_b | input | DIV_W | Divider B value minus one |
| rep_b | input | REP_W | Periods from divider B per sequence, minus one |
| tick_o | output | 1 | One-cycle pulse at the end of each output period |
| clk_o | output | 1 | Registered clock level, high for the first half of each period |

## Verification
The bench drives configuration changes at random cycles, most of them in the middle of a sequence. A design that loads the new values at every period boundary, instead of at every sequence boundary, would then produce a period of the wrong length. Zero-valued fields check the minus-one encoding: an off-by-one design would tick every second cycle, or would repeat a divider twice. In single mode the unused fields are scrambled on every cycle, which catches a repeat counter that keeps running and switches to divider B. The bench also checks the high time of `clk_o` with a divide of 1 and with odd divides, where a rounding or minimum-of-one mistake shows up as a wrong high count.

// File: rtl/dualdiv_pkg.sv
package dualdiv_pkg;
  typedef enum logic {
    PH_A = 1'b0,
    PH_B = 1'b1
  } ph_e;
endpackage

// File: rtl/dualdiv_cfg_hold.sv
module dualdiv_cfg_hold #(
  parameter int DIV_W = 8,
  parameter int REP_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic             dual_i,
  input  logic [DIV_W-1:0] div_a_i,
  input  logic [REP_W-1:0] rep_a_i,
  input  logic [DIV_W-1:0] div_b_i,
  input  logic [REP_W-1:0] rep_b_i,
  output logic             dual_q,
  output logic [DIV_W-1:0] div_a_q,
  output logic [REP_W-1:0] rep_a_q,
  output logic [DIV_W-1:0] div_b_q,
  output logic [REP_W-1:0] rep_b_q
);
  // Active configuration: captured in reset and at each sequence boundary.
  always_ff @(posedge clk) begin
    if (rst || load_i) begin
      dual_q  <= dual_i;
      div_a_q <= div_a_i;
      rep_a_q <= rep_a_i;
      div_b_q <= div_b_i;
      rep_b_q <= rep_b_i;
    end
  end

  // R6
  cfg_stable_chk: assert property (@(posedge clk) disable iff (rst)
    !load_i |=> ($stable(dual_q) && $stable(div_a_q) && $stable(rep_a_q) &&
                 $stable(div_b_q) && $stable(rep_b_q)));
endmodule

// File: rtl/dualdiv_period_ctr.sv
module dualdiv_period_ctr #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] div_i,
  output logic             last_o,
  output logic             high_o
);
  localparam int FW = DIV_W + 1;

  logic [DIV_W-1:0] cnt;
  logic [FW-1:0]    full_len;
  logic [FW-1:0]    half_len;

  always_comb begin
    full_len = {1'b0, div_i} + {{DIV_W{1'b0}}, 1'b1};
    half_len = full_len >> 1;
    if (half_len == '0) half_len = {{DIV_W{1'b0}}, 1'b1};
  end

  assign last_o = (cnt == div_i);
  assign high_o = ({1'b0, cnt} < half_len);

  always_ff @(posedge clk) begin
    if (rst || last_o) cnt <= '0;
    else               cnt <= cnt + DIV_W'(1);
  end

  // R8
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    cnt <= div_i);
endmodule

// File: rtl/dualdiv_phase_seq.sv
module dualdiv_phase_seq
  import dualdiv_pkg::*;
#(
  parameter int REP_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             period_end_i,
  input  logic             dual_i,
  input  logic [REP_W-1:0] rep_a_i,
  input  logic [REP_W-1:0] rep_b_i,
  output ph_e              phase_o,
  output logic             seq_end_o
);
  logic [REP_W-1:0] rcnt;

  assign seq_end_o = period_end_i &&
                     (!dual_i || (phase_o == PH_B && rcnt == rep_b_i));

  always_ff @(posedge clk) begin
    if (rst || !dual_i) begin
      phase_o <= PH_A;
      rcnt    <= '0;
    end else if (period_end_i) begin
      if (phase_o == PH_A) begin
        if (rcnt == rep_a_i) begin
          phase_o <= PH_B;
          rcnt    <= '0;
        end else begin
          rcnt <= rcnt + REP_W'(1);
        end
      end else begin
        if (rcnt == rep_b_i) begin
          phase_o <= PH_A;
          rcnt    <= '0;
        end else begin
          rcnt <= rcnt + REP_W'(1);
        end
      end
    end
  end

  // R7
  single_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !dual_i |-> (phase_o == PH_A && rcnt == '0));

  // R4
  phase_stable_chk: assert property (@(posedge clk) disable iff (rst)
    !period_end_i |=> $stable(phase_o));
endmodule

// File: rtl/dual_ratio_clkdiv.sv
module dual_ratio_clkdiv
  import dualdiv_pkg::*;
#(
  parameter int DIV_W = 8,
  parameter int REP_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             dual_en,
  input  logic [DIV_W-1:0] div_a,
  input  logic [REP_W-1:0] rep_a,
  input  logic [DIV_W-1:0] div_b,
  input  logic [REP_W-1:0] rep_b,
  output logic             tick_o,
  output logic             clk_o
);
  logic             act_dual;
  logic [DIV_W-1:0] act_div_a, act_div_b, cur_div;
  logic [REP_W-1:0] act_rep_a, act_rep_b;
  logic             period_end, seq_end, lvl;
  ph_e              phase;

  dualdiv_cfg_hold #(.DIV_W(DIV_W), .REP_W(REP_W)) u_cfg (
    .clk(clk), .rst(rst), .load_i(seq_end),
    .dual_i(dual_en), .div_a_i(div_a), .rep_a_i(rep_a),
    .div_b_i(div_b), .rep_b_i(rep_b),
    .dual_q(act_dual), .div_a_q(act_div_a), .rep_a_q(act_rep_a),
    .div_b_q(act_div_b), .rep_b_q(act_rep_b)
  );

  assign cur_div = (phase == PH_B) ? act_div_b : act_div_a;

  dualdiv_period_ctr #(.DIV_W(DIV_W)) u_period (
    .clk(clk), .rst(rst), .div_i(cur_div),
    .last_o(period_end), .high_o(lvl)
  );

  dualdiv_phase_seq #(.REP_W(REP_W)) u_seq (
    .clk(clk), .rst(rst), .period_end_i(period_end),
    .dual_i(act_dual), .rep_a_i(act_rep_a), .rep_b_i(act_rep_b),
    .phase_o(phase), .seq_end_o(seq_end)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      tick_o <= 1'b0;
      clk_o  <= 1'b0;
    end else begin
      tick_o <= period_end;
      clk_o  <= lvl;
    end
  end

  // R4
  seq_restart_chk: assert property (@(posedge clk) disable iff (rst)
    seq_end |=> (phase == PH_A));

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> (!tick_o && !clk_o));
endmodule

// File: tb/dual_ratio_clkdiv_tb.sv
`timescale 1ns/1ps
module dual_ratio_clkdiv_tb;
  localparam int DIV_W = 8;
  localparam int REP_W = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic dual_en = 1'b0;
  logic [DIV_W-1:0] div_a = '0, div_b = '0;
  logic [REP_W-1:0] rep_a = '0, rep_b = '0;
  logic tick_o, clk_o;

  always #2.5 clk = ~clk;

  dual_ratio_clkdiv #(.DIV_W(DIV_W), .REP_W(REP_W)) u_dut (
    .clk(clk), .rst(rst), .dual_en(dual_en),
    .div_a(div_a), .rep_a(rep_a), .div_b(div_b), .rep_b(rep_b),
    .tick_o(tick_o), .clk_o(clk_o)
  );

  int checks = 0, failures = 0;
  bit done = 0;

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  // Values seen by the design at each rising edge.
  logic s_rst, s_dual;
  int   s_da, s_ra, s_db, s_rb;
  always @(posedge clk) begin
    s_rst  <= rst;
    s_dual <= dual_en;
    s_da   <= int'(div_a);
    s_ra   <= int'(rep_a);
    s_db   <= int'(div_b);
    s_rb   <= int'(rep_b);
  end

  // Reference model of the expected period sequence.
  bit m_dual, m_phb;
  int m_da, m_ra, m_db, m_rb, m_rc;
  int ivl, hi, seqsum, idle;

  function automatic int half_of(int d);
    return (d / 2 < 1) ? 1 : d / 2;
  endfunction

  always @(negedge clk) begin
    if (!done) begin
      if (s_rst) begin
        // R1: quiet outputs in reset
        chk(!tick_o && !clk_o, "R1 reset outputs", int'({tick_o, clk_o}), 0);
        m_dual = s_dual; m_da = s_da; m_ra = s_ra; m_db = s_db; m_rb = s_rb;
        m_phb = 0; m_rc = 0; ivl = 0; hi = 0; seqsum = 0; idle = 0;
      end else begin
        ivl++; idle++;
        if (clk_o) hi++;
        if (idle > 70000) begin
          chk(0, "watchdog", idle, 0);
          finish_run();
        end
        if (tick_o) begin
          int exp_len;
          bit boundary;
          exp_len = m_phb ? m_db + 1 : m_da + 1;
          if (m_dual) chk(ivl == exp_len, "R4 R6 R3 period length", ivl, exp_len);
          else        chk(ivl == exp_len, "R2 R7 R3 period length", ivl, exp_len);
          chk(hi == half_of(exp_len), "R9 clk_o high time", hi, half_of(exp_len));
          seqsum += ivl;
          boundary = 0;
          if (!m_dual) boundary = 1;
          else if (!m_phb) begin
            if (m_rc == m_ra) begin m_phb = 1; m_rc = 0; end
            else m_rc++;
          end else begin
            if (m_rc == m_rb) begin boundary = 1; m_phb = 0; m_rc = 0; end
            else m_rc++;
          end
          if (boundary) begin
            if (m_dual) begin
              int exp_sum;
              exp_sum = (m_da + 1) * (m_ra + 1) + (m_db + 1) * (m_rb + 1);
              chk(seqsum == exp_sum, "R5 sequence total", seqsum, exp_sum);
            end
            m_dual = s_dual; m_da = s_da; m_ra = s_ra; m_db = s_db; m_rb = s_rb;
            m_phb = 0; m_rc = 0; seqsum = 0;
          end
          ivl = 0; hi = 0; idle = 0;
        end
      end
    end
  end

  task automatic set_cfg(bit d, int da, int ra, int db, int rb);
    @(posedge clk); #1;
    dual_en = d;
    div_a = DIV_W'(da); rep_a = REP_W'(ra);
    div_b = DIV_W'(db); rep_b = REP_W'(rb);
  endtask

  task automatic run(int n);
    repeat (n) @(posedge clk);
  endtask

  initial begin
    int seed;
    seed = $urandom(32'h5EED_0C1D);
    // R1: reset with single divide-by-5
    dual_en = 0; div_a = 8'd4; rep_a = 8'd3; div_b = 8'd9; rep_b = 8'd2;
    repeat (4) @(posedge clk);
    #1 rst = 0;
    run(40);
    // R3: divide by 1 in single mode
    set_cfg(0, 0, 0, 0, 0);
    run(20);
    // R7: unused fields scrambled in single mode
    set_cfg(0, 6, 0, 0, 0);
    for (int i = 0; i < 80; i++) begin
      @(posedge clk); #1;
      rep_a = REP_W'($urandom_range(0, 255));
      div_b = DIV_W'($urandom_range(0, 255));
      rep_b = REP_W'($urandom_range(0, 255));
    end
    // R4 R5: directed dual pattern
    set_cfg(1, 2, 2, 3, 1);
    run(200);
    // R3: all-zero dual fields
    set_cfg(1, 0, 0, 0, 0);
    run(20);
    // R9: odd and even divides in dual mode
    set_cfg(1, 6, 0, 1, 3);
    run(120);
    // R6: random changes at arbitrary cycles
    for (int i = 0; i < 40; i++) begin
      set_cfg($urandom_range(0, 1), $urandom_range(0, 15), $urandom_range(0, 7),
              $urandom_range(0, 15), $urandom_range(0, 7));
      run($urandom_range(5, 300));
    end
    // R2: largest divide
    set_cfg(0, 255, 0, 0, 0);
    run(900);
    run(50);
    finish_run();
  end

  initial begin
    #(5.0 * 190000);
    chk(0, "watchdog timeout", 0, 1);
    finish_run();
  end
endmodule